// File: doc/BRIEF.md
# I2S Audio Receive Channel

This block takes a serial audio stream in the common I2S format, turns it into samples, and stores them in a small word FIFO that a host reads one 32-bit word at a time. Samples can be 8, 16 or 32 bits wide. The block packs narrow samples into FIFO words, four 8-bit or two 16-bit samples per word, so that the FIFO holds as much audio as it can. In stereo mode both channels are kept in the order they arrive. In mono mode only the left channel is kept.

The receiver can be a bit-clock master or a slave, and this choice is independent of any transmit channel. As a master it divides the system clock to make its own bit clock, and it toggles word select after a programmed number of bit periods. As a slave it synchronises the external bit clock, word-select and data lines into the system clock domain and acts on the rising edges it detects. The system clock must run at least four times the bit rate.

Two comparators on the FIFO fill level drive an interrupt request and a DMA request, each with its own threshold. Separate controls mute the data, stop reception, or clear the channel.

Top module: `i2s_rx_channel`

## Requirements
- R1: Data is sampled on the rising bit-clock edge, MSB first. The first bit of a sample comes on the rising edge after the one at which word select is first seen changed. Word select 0 marks the left channel and 1 marks the right. The first rising edge after reset, clear or stop only records word select and starts no sample.
- R2: `cfg_size` encodes the sample width: 0 is 8 bits, 1 is 16 bits, 2 or 3 is 32 bits. Bits that arrive in a slot after the sample width has been reached are ignored.
- R3: 8-bit samples are packed four per FIFO word and 16-bit samples two per word. The first-received sample goes in bits [7:0] or [15:0] respectively. A word enters the FIFO only once it is full.
- R4: With `cfg_stereo`=1 every sample is kept, in arrival order. With `cfg_stereo`=0 only left samples (word select 0) are kept.
- R5: While `cfg_mute`=1, each completed sample is stored as zero.
- R6: While `cfg_stop`=1, no bit-clock edge is acted on, any sample in progress is abandoned, and `sck_o` and `ws_o` are held at 0. After stop is released, reception restarts at the next word-select change.
- R7: A one-cycle `cfg_reset` empties the FIFO, clears a partly packed word, clears the overrun flag and restarts the master clock outputs at 0.
- R8: The FIFO holds 8 words. `rd_data` shows the oldest word, or 0 when `level` is 0. `rd_en` removes one word when the FIFO is not empty and has no effect when it is empty.
- R9: A word completed while the FIFO is full is dropped. It sets `overrun`, which stays set until `cfg_reset` or `rst_n`.
- R10: `irq` is 1 exactly when `level` > `cfg_irq_lvl`. `dma_req` is 1 exactly when `level` > `cfg_dma_lvl`.
- R11: In master mode `sck_o` toggles every `cfg_div`+1 clock cycles. `ws_o` changes only on a falling `sck_o` and toggles every `cfg_ws_half` bit periods. Samples are taken on the block's own rising `sck_o` edges.
- R12: In slave mode `sck_o` and `ws_o` stay at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_master | input | 1 | 1: generate bit clock and word select |
| cfg_stereo | input | 1 | 1: keep both channels, 0: left only |
| cfg_size | input | 2 | Sample width code (0: 8, 1: 16, 2/3: 32) |
| cfg_stop | input | 1 | Halt reception and master clocks |
| cfg_mute | input | 1 | Store zeros in place of data |
| cfg_reset | input | 1 | Synchronous channel clear |
| cfg_div | input | DIV_W | Master bit-clock half period minus one, in clk cycles |
| cfg_ws_half | input | HALF_W | Master bits per word-select half period |
| cfg_irq_lvl | input | LVL_W | Interrupt threshold |
| cfg_dma_lvl | input | LVL_W | DMA request threshold |
| sck_i | input | 1 | Slave bit clock |
| ws_i | input | 1 | Slave word select |
| sd_i | input | 1 | Serial data |
| sck_o | output | 1 | Master bit clock |
| ws_o | output | 1 | Master word select |
| rd_en | input | 1 | Remove the oldest FIFO word |
| rd_data | output | 32 | Oldest FIFO word |
| level | output | LVL_W | Number of words in the FIFO |
| irq | output | 1 | Fill-level interrupt request |
| dma_req | output | 1 | Fill-level DMA request |
| overrun | output | 1 | Sticky dropped-word flag |

## Verification
The bound checker checks on every cycle that the fill level never exceeds the depth and never moves by more than one word per cycle. It also checks that overrun is set only from a full FIFO and stays set until a clear, that the master outputs stay quiet in slave or stopped mode, and that master word select changes only on a falling bit clock. Bit order, channel selection, the packing of 8- and 16-bit samples, muting, restart after stop, threshold outputs and the master bit-clock period depend on the data sent, so only the bench's scenarios can show them. The bench checks these by sending known sample streams and reading the FIFO words back.

// File: rtl/i2s_rx_channel.sv
module i2s_rx_channel #(
  parameter int DEPTH  = 8,
  parameter int DIV_W  = 8,
  parameter int HALF_W = 6,
  localparam int AW    = $clog2(DEPTH),
  localparam int LVL_W = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_master,
  input  logic              cfg_stereo,
  input  logic [1:0]        cfg_size,
  input  logic              cfg_stop,
  input  logic              cfg_mute,
  input  logic              cfg_reset,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [HALF_W-1:0] cfg_ws_half,
  input  logic [LVL_W-1:0]  cfg_irq_lvl,
  input  logic [LVL_W-1:0]  cfg_dma_lvl,
  input  logic              sck_i,
  input  logic              ws_i,
  input  logic              sd_i,
  output logic              sck_o,
  output logic              ws_o,
  input  logic              rd_en,
  output logic [31:0]       rd_data,
  output logic [LVL_W-1:0]  level,
  output logic              irq,
  output logic              dma_req,
  output logic              overrun
);

  logic [2:0] sck_p;
  logic [1:0] ws_p, sd_p;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_p <= '0;
      ws_p  <= '0;
      sd_p  <= '0;
    end else begin
      sck_p <= {sck_p[1:0], sck_i};
      ws_p  <= {ws_p[0], ws_i};
      sd_p  <= {sd_p[0], sd_i};
    end

  logic              s_rise, sd_s;
  assign s_rise = sck_p[1] & ~sck_p[2];
  assign sd_s   = sd_p[1];

  logic [DIV_W-1:0]  div_cnt;
  logic [HALF_W-1:0] ws_cnt;
  logic              tick, m_idle;
  assign tick   = div_cnt == cfg_div;
  assign m_idle = cfg_reset | ~cfg_master | cfg_stop;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_cnt <= '0;
      ws_cnt  <= '0;
      sck_o   <= 1'b0;
      ws_o    <= 1'b0;
    end else if (m_idle) begin
      div_cnt <= '0;
      ws_cnt  <= '0;
      sck_o   <= 1'b0;
      ws_o    <= 1'b0;
    end else if (tick) begin
      div_cnt <= '0;
      sck_o   <= ~sck_o;
      if (sck_o) begin
        if (ws_cnt == cfg_ws_half - 1'b1) begin
          ws_cnt <= '0;
          ws_o   <= ~ws_o;
        end else begin
          ws_cnt <= ws_cnt + 1'b1;
        end
      end
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end

  logic rise, ws_now;
  assign rise   = cfg_master ? (tick & ~sck_o & ~m_idle) : s_rise;
  assign ws_now = cfg_master ? ws_o : ws_p[1];

  logic [5:0]  nb;
  logic [31:0] mask;
  always_comb
    case (cfg_size)
      2'd0:    begin nb = 6'd8;  mask = 32'h0000_00FF; end
      2'd1:    begin nb = 6'd16; mask = 32'h0000_FFFF; end
      default: begin nb = 6'd32; mask = 32'hFFFF_FFFF; end
    endcase

  logic        seen, ws_prev, active, chan;
  logic [5:0]  bitcnt;
  logic [30:0] sh;
  logic [31:0] shifted, smp;
  logic        smp_done, keep;
  assign shifted  = {sh, sd_s};
  assign smp      = cfg_mute ? 32'd0 : (shifted & mask);
  assign smp_done = rise & ~cfg_stop & seen & active & (bitcnt == nb - 6'd1);
  assign keep     = cfg_stereo | ~chan;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      seen <= 1'b0; ws_prev <= 1'b0; active <= 1'b0; chan <= 1'b0;
      bitcnt <= '0; sh <= '0;
    end else if (cfg_reset || cfg_stop) begin
      seen <= 1'b0; ws_prev <= 1'b0; active <= 1'b0; chan <= 1'b0;
      bitcnt <= '0; sh <= '0;
    end else if (rise) begin
      ws_prev <= ws_now;
      if (!seen) begin
        seen <= 1'b1;
      end else begin
        if (active) begin
          sh     <= shifted[30:0];
          bitcnt <= bitcnt + 6'd1;
          if (bitcnt == nb - 6'd1) active <= 1'b0;
        end
        if (ws_now != ws_prev) begin
          active <= 1'b1;
          bitcnt <= '0;
          chan   <= ws_now;
        end
      end
    end

  logic [31:0] pk, merged;
  logic [1:0]  pk_cnt;
  logic        last, push;
  always_comb
    case (cfg_size)
      2'd0:    begin merged = pk | (smp << {pk_cnt, 3'b000}); last = pk_cnt == 2'd3; end
      2'd1:    begin merged = pk | (smp << {pk_cnt[0], 4'b0000}); last = pk_cnt[0]; end
      default: begin merged = smp; last = 1'b1; end
    endcase
  assign push = smp_done & keep & last;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pk <= '0; pk_cnt <= '0;
    end else if (cfg_reset) begin
      pk <= '0; pk_cnt <= '0;
    end else if (smp_done && keep) begin
      if (last) begin
        pk <= '0; pk_cnt <= '0;
      end else begin
        pk <= merged; pk_cnt <= pk_cnt + 2'd1;
      end
    end

  logic [31:0] mem [DEPTH];
  logic [AW:0] wp, rp;
  logic        full, pop, wr;
  assign level = wp - rp;
  assign full  = level == LVL_W'(DEPTH);
  assign pop   = rd_en & (level != '0);
  assign wr    = push & ~full & ~cfg_reset;

  always_ff @(posedge clk)
    if (wr) mem[wp[AW-1:0]] <= merged;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; overrun <= 1'b0;
    end else if (cfg_reset) begin
      wp <= '0; rp <= '0; overrun <= 1'b0;
    end else begin
      if (wr)          wp <= wp + 1'b1;
      if (pop)         rp <= rp + 1'b1;
      if (push && full) overrun <= 1'b1;
    end

  assign rd_data = (level == '0) ? 32'd0 : mem[rp[AW-1:0]];
  assign irq     = level > cfg_irq_lvl;
  assign dma_req = level > cfg_dma_lvl;

endmodule

module i2s_rx_chk #(
  parameter int DEPTH = 8,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_master,
  input logic             cfg_stop,
  input logic             cfg_reset,
  input logic             sck_o,
  input logic             ws_o,
  input logic [LVL_W-1:0] level,
  input logic             overrun
);

  // R8
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level) <= DEPTH);

  // R8
  level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_reset) |-> (int'(level) <= int'($past(level)) + 1) &&
                          (int'($past(level)) <= int'(level) + 1));

  // R9
  overrun_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> int'($past(level)) == DEPTH);

  // R9
  overrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !cfg_reset |=> overrun);

  // R6 R12
  quiet_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_master || cfg_stop) |=> !sck_o && !ws_o);

  // R11
  ws_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && $past(cfg_master) && !$past(cfg_stop) && !$past(cfg_reset) &&
     !$stable(ws_o)) |-> $fell(sck_o));

endmodule

bind i2s_rx_channel i2s_rx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_stop(cfg_stop),
  .cfg_reset(cfg_reset), .sck_o(sck_o), .ws_o(ws_o), .level(level),
  .overrun(overrun)
);

// File: tb/tb_i2s_rx_channel.sv
module tb_i2s_rx_channel;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic cfg_master = 0, cfg_stereo = 1, cfg_stop = 0, cfg_mute = 0, cfg_reset = 0;
  logic [1:0] cfg_size = 2;
  logic [7:0] cfg_div = 8'd3;
  logic [5:0] cfg_ws_half = 6'd16;
  logic [3:0] cfg_irq_lvl = 4'd0, cfg_dma_lvl = 4'd8;
  logic sck_i = 0, ws_i = 0, sd_i = 0, rd_en = 0;
  logic sck_o, ws_o, irq, dma_req, overrun;
  logic [31:0] rd_data;
  logic [3:0] level;

  i2s_rx_channel dut (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_stereo(cfg_stereo),
    .cfg_size(cfg_size), .cfg_stop(cfg_stop), .cfg_mute(cfg_mute),
    .cfg_reset(cfg_reset), .cfg_div(cfg_div), .cfg_ws_half(cfg_ws_half),
    .cfg_irq_lvl(cfg_irq_lvl), .cfg_dma_lvl(cfg_dma_lvl), .sck_i(sck_i),
    .ws_i(ws_i), .sd_i(sd_i), .sck_o(sck_o), .ws_o(ws_o), .rd_en(rd_en),
    .rd_data(rd_data), .level(level), .irq(irq), .dma_req(dma_req),
    .overrun(overrun)
  );

  int n_chk = 0, n_fail = 0;
  logic last_bit = 0, last_w = 0, flushed = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic w, input logic b);
    @(negedge clk); ws_i = w; sd_i = b; sck_i = 0;
    repeat (3) @(negedge clk);
    sck_i = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic begin_stream(input logic first_w);
    send_bit(~first_w, 1'b0);
    last_bit = 0; flushed = 0;
  endtask

  task automatic send_slot(input logic w, input logic [31:0] d, input int half);
    if (!flushed) send_bit(w, last_bit);
    flushed = 0;
    for (int i = half - 1; i >= 1; i--) send_bit(w, d[i]);
    last_bit = d[0]; last_w = w;
  endtask

  task automatic flush();
    send_bit(~last_w, last_bit);
    flushed = 1;
    repeat (10) @(negedge clk);
  endtask

  task automatic clear_ch();
    @(negedge clk); cfg_reset = 1;
    @(negedge clk); cfg_reset = 0;
  endtask

  task automatic pop_chk(input string req, input logic [31:0] exp);
    @(negedge clk); chk(req, rd_data, exp);
    rd_en = 1; @(negedge clk); rd_en = 0;
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    chk("R8 reset level", level, 0);
    chk("R8 reset rd_data", rd_data, 0);
    chk("R10 reset irq/dma", {irq, dma_req}, 0);
    chk("R9 reset overrun", overrun, 0);
    chk("R12 reset master outputs", {sck_o, ws_o}, 0);
  endtask

  task automatic t_stereo32();
    clear_ch(); cfg_size = 2; cfg_stereo = 1;
    begin_stream(0);
    send_slot(0, 32'h89AB_CDEF, 32);
    send_slot(1, 32'h0123_4567, 32);
    flush();
    chk("R1 level after two samples", level, 2);
    chk("R12 slave sck_o/ws_o", {sck_o, ws_o}, 0);
    pop_chk("R1 left word", 32'h89AB_CDEF);
    pop_chk("R4 right word", 32'h0123_4567);
  endtask

  task automatic t_pack16();
    clear_ch(); cfg_size = 1; cfg_stereo = 1;
    begin_stream(0);
    send_slot(0, {8'h0, 16'h1234, 8'hC3}, 24);
    send_slot(1, {8'h0, 16'hABCD, 8'h5A}, 24);
    send_slot(0, {8'h0, 16'h0F0F, 8'hFF}, 24);
    send_slot(1, {8'h0, 16'hF0F0, 8'h81}, 24);
    flush();
    chk("R3 16-bit words", level, 2);
    pop_chk("R2 R3 16-bit pack 0", 32'hABCD_1234);
    pop_chk("R2 R3 16-bit pack 1", 32'hF0F0_0F0F);
  endtask

  task automatic t_mono8();
    clear_ch(); cfg_size = 0; cfg_stereo = 0;
    begin_stream(0);
    for (int k = 0; k < 8; k++) begin
      send_slot(0, 32'h10 + k, 8);
      send_slot(1, 32'hE0 + k, 8);
    end
    flush();
    chk("R4 mono level", level, 2);
    pop_chk("R3 R4 8-bit mono 0", 32'h1312_1110);
    pop_chk("R3 R4 8-bit mono 1", 32'h1716_1514);
    cfg_stereo = 1;
  endtask

  task automatic t_mute();
    clear_ch(); cfg_size = 2; cfg_mute = 1;
    begin_stream(0);
    send_slot(0, 32'hDEAD_BEEF, 32);
    send_slot(1, 32'hCAFE_F00D, 32);
    flush();
    cfg_mute = 0;
    chk("R5 mute level", level, 2);
    pop_chk("R5 muted left", 0);
    pop_chk("R5 muted right", 0);
  endtask

  task automatic t_stop();
    clear_ch(); cfg_size = 2; cfg_stop = 1;
    begin_stream(0);
    send_slot(0, 32'h1111_1111, 32);
    send_slot(1, 32'h2222_2222, 32);
    flush();
    chk("R6 nothing stored while stopped", level, 0);
    cfg_stop = 0;
    begin_stream(0);
    send_slot(0, 32'h3333_4444, 32);
    send_slot(1, 32'h5555_6666, 32);
    flush();
    chk("R6 level after restart", level, 2);
    pop_chk("R6 restart left", 32'h3333_4444);
    pop_chk("R6 restart right", 32'h5555_6666);
  endtask

  task automatic t_clear_partial();
    clear_ch(); cfg_size = 1;
    begin_stream(0);
    send_slot(0, 32'h0000_9999, 16);
    flush();
    chk("R3 half word not stored", level, 0);
    clear_ch();
    begin_stream(0);
    send_slot(0, 32'h0000_1357, 16);
    send_slot(1, 32'h0000_2468, 16);
    flush();
    chk("R7 level after clear", level, 1);
    pop_chk("R7 partial word discarded", 32'h2468_1357);
  endtask

  task automatic t_levels();
    clear_ch(); cfg_size = 2; cfg_irq_lvl = 3; cfg_dma_lvl = 5;
    begin_stream(0);
    for (int k = 0; k < 4; k++) send_slot(k[0], 32'hC0DE_0000 + k, 32);
    flush();
    chk("R10 level 4", level, 4);
    chk("R10 irq above 3", irq, 1);
    chk("R10 dma not above 5", dma_req, 0);
    chk("R9 no overrun yet", overrun, 0);
    for (int k = 4; k < 10; k++) send_slot(k[0], 32'hC0DE_0000 + k, 32);
    flush();
    chk("R8 full level", level, 8);
    chk("R9 overrun set", overrun, 1);
    chk("R10 dma above 5", dma_req, 1);
    for (int k = 0; k < 8; k++) pop_chk("R8 R9 fifo order", 32'hC0DE_0000 + k);
    chk("R8 empty level", level, 0);
    chk("R8 empty rd_data", rd_data, 0);
    chk("R10 irq low when empty", irq, 0);
    rd_en = 1; @(negedge clk); rd_en = 0; @(negedge clk);
    chk("R8 read of empty", level, 0);
    chk("R9 overrun sticky", overrun, 1);
    clear_ch();
    chk("R7 clear drops overrun", overrun, 0);
    cfg_irq_lvl = 0; cfg_dma_lvl = 8;
  endtask

  task automatic t_master();
    int c0, per, slot, pos;
    logic psck, pws;
    logic [15:0] cur;
    clear_ch(); cfg_size = 1; cfg_stereo = 1; cfg_div = 3; cfg_ws_half = 16;
    cfg_master = 1;
    @(negedge clk);
    while (!sck_o) @(negedge clk);
    while (sck_o) @(negedge clk);
    while (!sck_o) @(negedge clk);
    c0 = 0;
    while (sck_o) begin @(negedge clk); c0++; end
    per = c0;
    while (!sck_o) begin @(negedge clk); per++; end
    chk("R11 bit clock period", per, 8);
    chk("R11 high phase", c0, 4);
    clear_ch();
    slot = 0; pos = 0; cur = 0; psck = 0; pws = 0;
    for (int c = 0; c < 8000 && level < 3; c++) begin
      @(negedge clk);
      if (psck && !sck_o) begin
        if (ws_o != pws) begin
          sd_i = cur[0];
          slot++;
          cur = 16'h5000 + 16'(slot);
          pos = 15;
        end else if (pos > 0) begin
          sd_i = cur[pos];
          pos--;
        end
      end
      psck = sck_o; pws = ws_o;
    end
    chk("R11 master words", level, 3);
    pop_chk("R11 master word 0", 32'h5002_5001);
    pop_chk("R11 master word 1", 32'h5004_5003);
    pop_chk("R11 master word 2", 32'h5006_5005);
    cfg_stop = 1;
    repeat (12) @(negedge clk);
    chk("R6 master outputs held in stop", {sck_o, ws_o}, 0);
    cfg_stop = 0; cfg_master = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_stereo32();
    t_pack16();
    t_mono8();
    t_mute();
    t_stop();
    t_clear_partial();
    t_levels();
    t_master();
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    summary();
    $finish;
  end
endmodule